// File: doc/BRIEF.md
# Tachometer Speed Discriminator with Lock Window

This block judges the speed of a brushless motor from its tachometer pulse train. On every rising edge of the tachometer input it counts how many reference ticks passed since the previous rising edge. The ticks are the cycles in which `tick_en` is high, and the reference is the multiplied external speed clock. It compares that count with a target period chosen by two select pins.

It drives two results:
- `dout` tells the outer speed loop whether the motor is running slow (high) or fast or exact (low).
- `ld_n` is an active-low flag that goes low while the period lies inside a symmetric window of one sixteenth of the target.

The period counter stops at twice the target. A motor that has stalled is therefore flagged as slow and out of lock without waiting for another pulse. The power-up reset is applied as a synchronous active-high input.

Top module: `spdisc_top`

## Requirements
- R1: The target count T comes from the select pins as follows. `n1`=1 and `n2`=1 gives 128. `n1`=1 and `n2`=0 gives 512. `n1`=0 and `n2`=1 gives 256. `n1`=0 and `n2`=0 gives 1024. A select pin left open on the board reads as 1.
- R2: The measured period M is the number of cycles with `tick_en`=1, counted from the cycle in which a rising edge of `fg` is sampled, up to but not including the cycle of the next sampled rising edge.
- R3: After each measured period, `ld_n` is 0 when T - T/16 <= M <= T + T/16, with both bounds included. Otherwise `ld_n` is 1.
- R4: After each measured period, `dout` is 1 when M > T and 0 when M <= T.
- R5: `dout` and `ld_n` change only in the clock cycle after a sampled rising edge, or after the counter reaches its limit. At all other times they hold their values.
- R6: During reset and after it, `dout` is 0 and `ld_n` is 1. The first rising edge after reset only starts a measurement and leaves both outputs unchanged.
- R7: The count stops at 2T. When it reaches 2T without a new edge, `dout` goes to 1 and `ld_n` goes to 1 within two cycles. A period of 2T or more is judged as M = 2T.
- R8: The select pins are sampled at each rising edge of `fg`. The target they give applies to the period that starts at that edge. A change in the pins during a period does not alter the judgment of that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Reference tick; each high cycle adds one count |
| fg | input | 1 | Tachometer pulse, already synchronized to `clk` |
| n1 | input | 1 | Target select pin 1 |
| n2 | input | 1 | Target select pin 2 |
| dout | output | 1 | Speed error sign: 1 = slow, 0 = fast or exact |
| ld_n | output | 1 | Lock flag, low while the period is inside the window |

## Verification
Results for a period are registered in the cycle of the rising edge that ends it, so they appear one clock later. The bench raises `fg` on a falling clock edge and reads both outputs at the next falling edge, which comes after exactly one rising edge.

For every target the sweep places the period just inside and just outside each window bound, and on and beside T. It also checks periods beyond 2T and half-rate ticking.

A stall is checked several cycles after the count can have reached 2T, which leaves margin for the one-cycle delay in R7. Pin changes are made in the middle of a period, to show that they take effect one edge later.

// File: rtl/spdisc_pkg.sv
package spdisc_pkg;

    localparam int unsigned DEF_BASE = 128;

    typedef struct packed {
        logic slow;
        logic locked;
    } verdict_t;

    // select pins -> left shift of the base count (11:0, 01:1, 10:2, 00:3)
    function automatic logic [1:0] sel_shift(input logic n1, input logic n2);
        return {~n2, ~n1};
    endfunction

endpackage

// File: rtl/spdisc_edge.sv
module spdisc_edge (
    input  logic clk,
    input  logic rst,
    input  logic fg,
    output logic fg_rise
);
    logic fg_q;

    always_ff @(posedge clk) begin
        if (rst) fg_q <= 1'b1;
        else     fg_q <= fg;
    end

    assign fg_rise = fg & ~fg_q;
endmodule

// File: rtl/spdisc_target.sv
module spdisc_target #(
    parameter int unsigned BASE  = 128,
    parameter int          CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fg_rise,
    input  logic             n1,
    input  logic             n2,
    output logic [CNT_W-1:0] tgt
);
    import spdisc_pkg::*;

    localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE);

    logic [CNT_W-1:0] live;
    assign live = BASE_V << sel_shift(n1, n2);

    always_ff @(posedge clk) begin
        if (rst || fg_rise) tgt <= live;
    end
endmodule

// File: rtl/spdisc_period.sv
module spdisc_period #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             fg_rise,
    input  logic [CNT_W-1:0] tgt,
    output logic [CNT_W-1:0] cnt,
    output logic             sat_hit
);
    logic [CNT_W-1:0] limit;
    assign limit = tgt << 1;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (fg_rise)
            cnt <= {{(CNT_W-1){1'b0}}, tick_en};
        else if (tick_en && cnt < limit)
            cnt <= cnt + 1'b1;
    end

    assign sat_hit = !fg_rise && (cnt >= limit);
endmodule

// File: rtl/spdisc_judge.sv
module spdisc_judge #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fg_rise,
    input  logic             sat_hit,
    input  logic [CNT_W-1:0] meas,
    input  logic [CNT_W-1:0] tgt,
    output logic             have_ref,
    output logic             dout,
    output logic             ld_n
);
    import spdisc_pkg::*;

    verdict_t         v;
    logic [CNT_W-1:0] tol;

    always_comb begin
        tol      = tgt >> 4;
        v.slow   = meas > tgt;
        v.locked = (meas >= tgt - tol) && (meas <= tgt + tol);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_ref <= 1'b0;
            dout     <= 1'b0;
            ld_n     <= 1'b1;
        end else if (fg_rise) begin
            have_ref <= 1'b1;
            if (have_ref) begin
                dout <= v.slow;
                ld_n <= ~v.locked;
            end
        end else if (sat_hit && have_ref) begin
            dout <= 1'b1;
            ld_n <= 1'b1;
        end
    end
endmodule

// File: rtl/spdisc_top.sv
module spdisc_top #(
    parameter int unsigned BASE  = spdisc_pkg::DEF_BASE,
    parameter int          CNT_W = $clog2(BASE * 16) + 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic fg,
    input  logic n1,
    input  logic n2,
    output logic dout,
    output logic ld_n
);
    logic             fg_rise;
    logic             sat_hit;
    logic             have_ref;
    logic [CNT_W-1:0] tgt_q;
    logic [CNT_W-1:0] cnt;

    spdisc_edge u_edge (
        .clk(clk), .rst(rst), .fg(fg), .fg_rise(fg_rise)
    );

    spdisc_target #(.BASE(BASE), .CNT_W(CNT_W)) u_target (
        .clk(clk), .rst(rst), .fg_rise(fg_rise), .n1(n1), .n2(n2), .tgt(tgt_q)
    );

    spdisc_period #(.CNT_W(CNT_W)) u_period (
        .clk(clk), .rst(rst), .tick_en(tick_en), .fg_rise(fg_rise),
        .tgt(tgt_q), .cnt(cnt), .sat_hit(sat_hit)
    );

    spdisc_judge #(.CNT_W(CNT_W)) u_judge (
        .clk(clk), .rst(rst), .fg_rise(fg_rise), .sat_hit(sat_hit),
        .meas(cnt), .tgt(tgt_q), .have_ref(have_ref), .dout(dout), .ld_n(ld_n)
    );
endmodule

// File: rtl/spdisc_checks.sv
module spdisc_checks #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             fg_rise,
    input logic             sat_hit,
    input logic             have_ref,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] tgt,
    input logic             dout,
    input logic             ld_n
);
    // R5: outputs move only after an edge or the limit
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(fg_rise || sat_hit) |=> $stable(dout) && $stable(ld_n));

    // R7: the count never passes twice the target
    p_cnt_cap_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= (tgt << 1));

    // R7: reaching the limit forces slow and unlocked
    p_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (sat_hit && have_ref) |=> dout && ld_n);

    // R6: state right after reset
    p_reset_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ld_n && !dout);

    // R1: target is always one power of two
    p_target_pow2_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(tgt) == 1);
endmodule

bind spdisc_top spdisc_checks #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .fg_rise(fg_rise), .sat_hit(sat_hit),
    .have_ref(have_ref), .cnt(cnt), .tgt(tgt_q), .dout(dout), .ld_n(ld_n)
);

// File: tb/tb_spdisc_top.sv
module tb_spdisc_top;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b1;
    logic fg = 1'b0;
    logic n1 = 1'b1;
    logic n2 = 1'b1;
    logic dout, ld_n;
    logic tick_alt = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    spdisc_top #(.BASE(BASE)) dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .fg(fg),
        .n1(n1), .n2(n2), .dout(dout), .ld_n(ld_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (tick_alt) tick_en <= ~tick_en;

    function automatic int tgt_of(bit a, bit b);
        if (a && b) return 128;
        if (a && !b) return 512;
        if (!a && b) return 256;
        return 1024;
    endfunction

    task automatic chk(string req, bit exp_dout, bit exp_ldn);
        checks++;
        if (dout !== exp_dout || ld_n !== exp_ldn) begin
            fails++;
            $display("FAIL %s: dout=%b ld_n=%b expected dout=%b ld_n=%b",
                     req, dout, ld_n, exp_dout, exp_ldn);
        end
    endtask

    task automatic rise();
        @(negedge clk) fg = 1'b1;
        @(negedge clk) fg = 1'b0;
    endtask

    task automatic gap(int d);
        repeat (d - 2) @(negedge clk);
    endtask

    task automatic expect_period(string req, int m, int t);
        int mm;
        int tol;
        mm  = (m > 2 * t) ? 2 * t : m;
        tol = t / 16;
        chk(req, mm > t, !((mm >= t - tol) && (mm <= t + tol)));
    endtask

    initial begin
        int t;
        int tol;
        repeat (3) @(negedge clk);
        chk("R6 reset", 1'b0, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 after reset", 1'b0, 1'b1);
        rise();
        chk("R6 first edge", 1'b0, 1'b1);
        gap(BASE);
        rise();
        expect_period("R3 first period", BASE, BASE);

        for (int code = 0; code < 4; code++) begin
            n1 = code[1];
            n2 = code[0];
            t = tgt_of(n1, n2);
            tol = t / 16;
            gap(t);
            rise();
            for (int k = 0; k < 8; k++) begin
                int d;
                case (k)
                    0: d = t;
                    1: d = t + tol;
                    2: d = t + tol + 1;
                    3: d = t - tol;
                    4: d = t - tol - 1;
                    5: d = t + 1;
                    6: d = t - 1;
                    default: d = 2 * t + 10;
                endcase
                gap(d);
                rise();
                case (k)
                    0, 5, 6: expect_period("R4 near target (R1 table)", d, t);
                    7: expect_period("R7 long period", d, t);
                    default: expect_period("R3 window bound", d, t);
                endcase
            end
        end

        // R8: pin change in mid-period applies one edge later
        n1 = 1'b1; n2 = 1'b1;
        gap(128); rise();
        gap(128); rise();
        expect_period("R8 setup", 128, 128);
        repeat (50) @(negedge clk);
        n1 = 1'b0; n2 = 1'b0;
        gap(128 - 50); rise();
        expect_period("R8 old target kept", 128, 128);
        gap(1024); rise();
        expect_period("R8 new target used", 1024, 1024);

        // R2: half-rate ticks
        n1 = 1'b1; n2 = 1'b1;
        gap(1024); rise();
        tick_alt = 1'b1;
        gap(256); rise();
        gap(256); rise();
        expect_period("R2 half rate locked", 128, 128);
        gap(274); rise();
        expect_period("R2 half rate slow", 137, 128);
        tick_alt = 1'b0;
        tick_en = 1'b1;
        gap(256); rise();
        gap(128); rise();
        expect_period("R2 full rate again", 128, 128);

        // R5: no edge, no change
        repeat (100) @(negedge clk);
        chk("R5 hold", 1'b0, 1'b0);

        // R7: stall
        repeat (2 * 128 + 10) @(negedge clk);
        chk("R7 stall", 1'b1, 1'b1);

        done = 1;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected done=1");
        end
        done = 1;
    end

    initial begin
        wait (done);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule